// File: doc/BRIEF.md
# Interleaved Replica Pipeline Wrapper

This block turns a slow, purely combinational function into a unit that looks from outside exactly like a K-stage pipeline. It instantiates K identical copies of the function, each fronted by its own operand holding register. A modulo-K counter steers every incoming operand into the next copy in rotation. That copy then keeps its operand frozen while its logic settles over several clock periods. An output multiplexer, indexed from the same counter, picks the copy whose result is now due, and a single output register presents it.

A new operand may be offered on every cycle, and each result emerges exactly K cycles after its operand. The throughput is one result per clock, even though no single copy can produce an answer within one period. A valid flag travels alongside each captured operand, so idle slots stay idle at the output. The function in this instance is a fixed placeholder polynomial, x*x + 3*x, evaluated on a W-bit operand with a 2W-bit result.

Top module: `ilv_pipe_wrap`

## Requirements
- R1: When out_valid is 1, out_data equals (x*x + 3*x) modulo 2^(2W), where x is the unsigned in_data that was presented with in_valid = 1 exactly K cycles earlier.
- R2: An operand presented in cycle n produces its result in cycle n+K, never earlier or later (default K = 4).
- R3: An operand is accepted on every clock cycle; K or more back-to-back valid operands each produce their own correct result in consecutive cycles.
- R4: out_valid in cycle n+K equals in_valid in cycle n; a cycle presented with in_valid = 0 yields out_valid = 0 K cycles later.
- R5: A synchronous active-high reset drives out_valid and out_data to 0 in the cycle after the reset edge, and out_valid stays 0 for the first K cycles after reset is released.
- R6: Consecutive cycles load the operand registers of copies 0, 1, ..., K-1 in strict rotation, exactly one copy per cycle, and a copy's held operand does not change on any cycle in which that copy is not loaded.
- R7: Operand boundary values are exact: x = 0 gives 0, x = 1 gives 4, and x = 2^W-1 wraps to (2^W-1)^2 + 3*(2^W-1) mod 2^(2W) (254 for W = 8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| reset | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks in_data as a live operand this cycle |
| in_data | input | W | Unsigned operand |
| out_valid | output | 1 | Marks out_data as a live result |
| out_data | output | 2W | Function result, registered |

## Verification
On every cycle the checker confirms that out_valid and out_data match an independent window of the last K offered operands, that exactly one copy loads per cycle and the loading copy advances by one each cycle, that idle copies keep their operands, and that reset clears the output. What only the bench's scenarios show is the behaviour across whole traffic patterns: dense back-to-back streams, sparse and random valid gaps, the wrap of the largest operand, and a reset dropped into the middle of live traffic followed by a clean restart.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int unsigned DEF_DATA_W = 8;
    localparam int unsigned DEF_COPIES = 4;

    // Width of an index able to name n copies (never below one bit).
    function automatic int unsigned idx_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Placeholder slow function, evaluated wide; callers truncate.
    function automatic logic [63:0] poly_eval(input logic [31:0] x);
        logic [63:0] xw;
        xw = {32'd0, x};
        return (xw * xw) + (64'd3 * xw);
    endfunction

endpackage

// File: rtl/ilv_rr_sel.sv
module ilv_rr_sel #(
    parameter int unsigned K  = 4,
    parameter int unsigned SW = 2
) (
    input  logic          clk,
    input  logic          reset,
    output logic [SW-1:0] cap_idx,
    output logic [SW-1:0] due_idx
);
    localparam logic [SW-1:0] LAST = SW'(K - 1);

    logic [SW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (reset) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + SW'(1);
        end
    end

    // The copy loaded K-1 cycles ago is the one after the current in rotation.
    always_comb begin
        cap_idx = cnt_q;
        due_idx = (cnt_q == LAST) ? '0 : cnt_q + SW'(1);
    end
endmodule

// File: rtl/ilv_copy.sv
module ilv_copy #(
    parameter int unsigned W  = 8,
    parameter int unsigned RW = 16
) (
    input  logic          clk,
    input  logic          reset,
    input  logic          load,
    input  logic          in_vld,
    input  logic [W-1:0]  in_data,
    output logic          hold_vld,
    output logic [W-1:0]  hold_data,
    output logic [RW-1:0] result
);
    import ilv_pkg::*;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] data;
    } slot_t;

    slot_t slot_q;

    always_ff @(posedge clk) begin
        if (reset) begin
            slot_q <= '0;
        end else if (load) begin
            slot_q.vld  <= in_vld;
            slot_q.data <= in_data;
        end
    end

    logic [63:0] wide;

    always_comb begin
        wide      = poly_eval(32'(slot_q.data));
        result    = wide[RW-1:0];
        hold_vld  = slot_q.vld;
        hold_data = slot_q.data;
    end
endmodule

// File: rtl/ilv_out_stage.sv
module ilv_out_stage #(
    parameter int unsigned K  = 4,
    parameter int unsigned SW = 2,
    parameter int unsigned RW = 16
) (
    input  logic            clk,
    input  logic            reset,
    input  logic [SW-1:0]   due_idx,
    input  logic [K-1:0]    vld_vec,
    input  logic [K*RW-1:0] res_flat,
    output logic            out_valid,
    output logic [RW-1:0]   out_data
);
    logic          pick_vld;
    logic [RW-1:0] pick_res;

    always_comb begin
        pick_vld = 1'b0;
        pick_res = '0;
        for (int i = 0; i < int'(K); i++) begin
            if (due_idx == SW'(i)) begin
                pick_vld = vld_vec[i];
                pick_res = res_flat[i*RW +: RW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (reset) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= pick_vld;
            out_data  <= pick_res;
        end
    end
endmodule

// File: rtl/ilv_pipe_wrap.sv
module ilv_pipe_wrap #(
    parameter int unsigned W = ilv_pkg::DEF_DATA_W,
    parameter int unsigned K = ilv_pkg::DEF_COPIES
) (
    input  logic           clk,
    input  logic           reset,
    input  logic           in_valid,
    input  logic [W-1:0]   in_data,
    output logic           out_valid,
    output logic [2*W-1:0] out_data
);
    localparam int unsigned SW = ilv_pkg::idx_width(K);
    localparam int unsigned RW = 2 * W;

    initial begin
        if (K < 2) $error("ilv_pipe_wrap: K must be at least 2");
    end

    logic [SW-1:0]   cap_idx;
    logic [SW-1:0]   due_idx;
    logic [K-1:0]    load_vec;
    logic [K-1:0]    vld_vec;
    logic [K*W-1:0]  hold_flat;
    logic [K*RW-1:0] res_flat;

    ilv_rr_sel #(.K(K), .SW(SW)) u_sel (
        .clk     (clk),
        .reset   (reset),
        .cap_idx (cap_idx),
        .due_idx (due_idx)
    );

    for (genvar g = 0; g < int'(K); g++) begin : g_copy
        assign load_vec[g] = (cap_idx == SW'(g));

        ilv_copy #(.W(W), .RW(RW)) u_copy (
            .clk       (clk),
            .reset     (reset),
            .load      (load_vec[g]),
            .in_vld    (in_valid),
            .in_data   (in_data),
            .hold_vld  (vld_vec[g]),
            .hold_data (hold_flat[g*W +: W]),
            .result    (res_flat[g*RW +: RW])
        );
    end

    ilv_out_stage #(.K(K), .SW(SW), .RW(RW)) u_out (
        .clk       (clk),
        .reset     (reset),
        .due_idx   (due_idx),
        .vld_vec   (vld_vec),
        .res_flat  (res_flat),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: rtl/ilv_pipe_chk.sv
module ilv_pipe_chk #(
    parameter int unsigned W = 8,
    parameter int unsigned K = 4
) (
    input logic           clk,
    input logic           reset,
    input logic           in_valid,
    input logic [W-1:0]   in_data,
    input logic           out_valid,
    input logic [2*W-1:0] out_data,
    input logic [K-1:0]   load_vec,
    input logic [K*W-1:0] hold_flat
);
    import ilv_pkg::*;

    logic [K-1:0] vsh;
    logic [W-1:0] dsh [K];
    logic [63:0]  ref_wide;

    always_ff @(posedge clk) begin
        if (reset) begin
            vsh <= '0;
            for (int j = 0; j < int'(K); j++) dsh[j] <= '0;
        end else begin
            vsh <= {vsh[K-2:0], in_valid};
            dsh[0] <= in_data;
            for (int j = 1; j < int'(K); j++) dsh[j] <= dsh[j-1];
        end
    end

    always_comb ref_wide = poly_eval(32'(dsh[K-1]));

    // R4
    valid_lag_chk: assert property (@(posedge clk) disable iff (reset)
        out_valid == vsh[K-1]);

    // R1
    data_value_chk: assert property (@(posedge clk) disable iff (reset)
        out_valid |-> (out_data == ref_wide[2*W-1:0]));

    // R5
    reset_clear_chk: assert property (@(posedge clk)
        reset |=> (!out_valid && out_data == '0));

    // R6
    one_loader_chk: assert property (@(posedge clk) disable iff (reset)
        $countones(load_vec) == 1);

    for (genvar i = 0; i < int'(K); i++) begin : g_cp
        // R6
        rotate_next_chk: assert property (@(posedge clk) disable iff (reset)
            load_vec[i] |=> load_vec[(i + 1) % K]);
        // R6
        hold_still_chk: assert property (@(posedge clk) disable iff (reset)
            !load_vec[i] |=> $stable(hold_flat[i*W +: W]));
    end
endmodule

bind ilv_pipe_wrap ilv_pipe_chk #(.W(W), .K(K)) u_chk (
    .clk       (clk),
    .reset     (reset),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .load_vec  (load_vec),
    .hold_flat (hold_flat)
);

// File: tb/tb_ilv_pipe_wrap.sv
`timescale 1ns/1ps
module tb_ilv_pipe_wrap;
    localparam int W = 8;
    localparam int K = 4;

    logic           clk = 1'b0;
    logic           reset = 1'b1;
    logic           in_valid = 1'b0;
    logic [W-1:0]   in_data = '0;
    logic           out_valid;
    logic [2*W-1:0] out_data;

    int errors = 0;
    int checks = 0;
    int t = 0;
    bit finished = 1'b0;
    bit           hv [0:4095];
    logic [W-1:0] hd [0:4095];

    always #2.5 clk = ~clk;

    ilv_pipe_wrap #(.W(W), .K(K)) dut (
        .clk       (clk),
        .reset     (reset),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic logic [2*W-1:0] ref_f(input logic [W-1:0] x);
        int unsigned v;
        v = int'(x) * int'(x) + 3 * int'(x);
        return v[2*W-1:0];
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0d act=%0b exp=%0b", req, t, act, exp);
        end
    endtask

    task automatic check_word(input string req, input logic [2*W-1:0] act,
                              input logic [2*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0d act=%0d exp=%0d", req, t, act, exp);
        end
    endtask

    // One cycle: check the output of this cycle, then offer the next operand.
    task automatic step(input string req, input bit v, input logic [W-1:0] d);
        @(negedge clk);
        if (t < K) begin
            check_bit("R5 R4", out_valid, 1'b0);
        end else begin
            // R2 R4: valid lags input by exactly K cycles
            check_bit("R2 R4", out_valid, hv[t-K]);
            if (hv[t-K]) check_word(req, out_data, ref_f(hd[t-K]));
        end
        in_valid = v;
        in_data  = d;
        hv[t] = v;
        hd[t] = d;
        t++;
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        reset = 1'b1;
        in_valid = 1'b0;
        for (int i = 0; i < cycles; i++) @(negedge clk);
        // R5: output cleared by the reset edges
        check_bit("R5", out_valid, 1'b0);
        check_word("R5", out_data, '0);
        reset = 1'b0;
        t = 0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        do_reset(3);
        // R7: boundary operands back to back
        step("R7", 1, 8'd0);
        step("R7", 1, 8'd1);
        step("R7", 1, 8'd255);
        step("R7", 1, 8'd128);
        step("R7", 1, 8'd254);
        step("R7", 0, 8'd255);
        for (int i = 0; i < K + 1; i++) step("R7", 0, 8'd0);
        // R1: random valid pattern and data
        for (int i = 0; i < 300; i++)
            step("R1", ($urandom % 10) < 7, W'($urandom));
        // R3: dense back-to-back stream
        for (int i = 0; i < 64; i++) step("R3", 1, W'($urandom));
        // R4: sparse operands with idle gaps
        for (int i = 0; i < 40; i++) step("R4", (i % 5) == 0, W'($urandom));
        // R5: reset dropped into live traffic, then restart
        for (int i = 0; i < 3; i++) step("R5", 1, W'($urandom));
        do_reset(2);
        for (int i = 0; i < 100; i++) step("R5", ($urandom % 2) == 1, W'($urandom));
        // R6: rotation visible as one result per cycle across all copies
        for (int i = 0; i < 3 * K; i++) step("R6", 1, W'(i * 37));
        for (int i = 0; i < K + 1; i++) step("R1", 0, '0);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog t=%0d act=hung exp=done", t);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule